// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream from a three-wire serial audio link (bit clock, frame clock, data) and turns it into a parallel left and right sample pair with a one-cycle valid strobe. All three serial lines are brought into the system clock domain and oversampled. Each rising bit-clock edge samples one data bit and the current frame-clock level. A frame-clock transition seen on such an edge opens a new half-frame. A low frame clock carries the left channel and a high frame clock carries the right channel.

A 3-bit format code selects the slot window and the bit order used within each 32-slot half-frame. Every word shorter than 24 bits is sign-extended to 24 bits. A half-frame that does not hold exactly 32 bit-clock periods is reported as a frame error, and its word is discarded. A format code outside the seven defined framings raises a format-error flag, and the stream is then decoded as I2S.

Top module: `ausr_rx`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `left_sample`, `right_sample`, `sample_valid`, `frame_err` and `fmt_err` are all zero.
- R2: Format code 000 (I2S) captures 24 bits MSB first, from slot 1 to slot 24 of the half-frame. Slot 0 is the bit sampled on the edge where the frame-clock change is first seen. A low frame clock means left.
- R3: Format code 001 (left-justified) captures 24 bits MSB first, from slot 0 to slot 23.
- R4: Format code 010 (right-justified, LSB first) captures 24 bits LSB first, from slot 8 to slot 31, so the MSB sits in the last slot.
- R5: Format codes 011, 100, 101 and 110 select right-justified MSB-first words of 24, 20, 18 and 16 bits. Each word ends in slot 31. The result is sign-extended from its top bit to 24 bits.
- R6: Data bits in slots outside the selected window have no effect on the output sample.
- R7: `sample_valid` is high for exactly one clock cycle per completed left-then-right pair. It rises after the first bit of the following half-frame is sampled, and it presents both words of the pair at once.
- R8: A half-frame that does not hold exactly 32 bit-clock periods makes `frame_err` pulse for one cycle at its closing boundary. Its word is dropped, and no `sample_valid` is produced for the pair it belongs to.
- R9: Format code 111 drives `fmt_err` high while it is applied, and the stream is decoded exactly as for code 000.
- R10: The format code is taken at each half-frame boundary. A new code therefore applies from the next half-frame onward and does not affect the half-frame already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrclk | input | 1 | Frame clock; low selects left, high selects right |
| sdata | input | 1 | Serial data |
| fmt_code | input | 3 | Framing select code |
| left_sample | output | 24 | Left word, sign-extended |
| right_sample | output | 24 | Right word, sign-extended |
| sample_valid | output | 1 | One-cycle strobe per stereo pair |
| frame_err | output | 1 | One-cycle pulse for a half-frame of the wrong length |
| fmt_err | output | 1 | High while the undefined format code is applied |

## Verification
The bench builds the block with its default parameters: a 24-bit sample, 32 slots per half-frame and a two-stage input synchronizer. Every slot window, the 8-slot offset of the LSB-first mode and the four right-justified word lengths are therefore exercised at their true sizes. The bit clock runs at one eighth of the system clock, which leaves several oversampled cycles between edges. Random data fills the padding slots, so any leakage from outside the selected window corrupts the sample. The format changes between back-to-back frames, which tests the boundary latching. Half-frames of 31 and 33 bits test the length check.

// File: rtl/ausr_pkg.sv
package ausr_pkg;

  localparam int SAMPLE_W = 24;

  typedef enum logic [2:0] {
    FMT_I2S    = 3'd0,
    FMT_LJ     = 3'd1,
    FMT_RJ_LSB = 3'd2,
    FMT_RJ24   = 3'd3,
    FMT_RJ20   = 3'd4,
    FMT_RJ18   = 3'd5,
    FMT_RJ16   = 3'd6,
    FMT_UNDEF  = 3'd7
  } fmt_e;

  // Map the raw code onto a usable framing; the undefined code decodes as I2S.
  function automatic fmt_e fmt_sanitize(logic [2:0] code);
    return (code == 3'd7) ? FMT_I2S : fmt_e'(code);
  endfunction

  function automatic int word_len(fmt_e f, int dw);
    case (f)
      FMT_RJ20: return 20;
      FMT_RJ18: return 18;
      FMT_RJ16: return 16;
      default:  return dw;
    endcase
  endfunction

  function automatic logic lsb_first(fmt_e f);
    return f == FMT_RJ_LSB;
  endfunction

  // True when slot idx of a half-frame carries a data bit for framing f.
  function automatic logic in_window(fmt_e f, int idx, int slots, int dw);
    case (f)
      FMT_I2S: return (idx >= 1) && (idx <= dw);
      FMT_LJ:  return idx < dw;
      default: return (idx >= slots - word_len(f, dw)) && (idx < slots);
    endcase
  endfunction

endpackage

// File: rtl/ausr_bitclk.sv
module ausr_bitclk #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_i,
  input  logic lr_i,
  input  logic sd_i,
  output logic bit_stb,
  output logic bit_lr,
  output logic bit_sd
);

  localparam int LINES = 3;

  logic [LINES-1:0] chain [STAGES];
  logic             bclk_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= {sd_i, lr_i, bclk_i};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_q  <= 1'b0;
      bit_stb <= 1'b0;
      bit_lr  <= 1'b1;
      bit_sd  <= 1'b0;
    end else begin
      bclk_q  <= chain[STAGES-1][0];
      bit_stb <= chain[STAGES-1][0] & ~bclk_q;
      bit_lr  <= chain[STAGES-1][1];
      bit_sd  <= chain[STAGES-1][2];
    end
  end

  // R7 support: one strobe per bit-clock rising edge, never two in a row.
  p_stb_single_r7: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

endmodule

// File: rtl/ausr_slicer.sv
module ausr_slicer
  import ausr_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int SLOTS = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_stb,
  input  logic          bit_lr,
  input  logic          bit_sd,
  input  fmt_e          fmt_sel,
  output logic          hf_done,
  output logic          hf_ok,
  output logic          hf_chan,
  output logic [DW-1:0] hf_word
);

  localparam int            CW       = $clog2(SLOTS) + 2;
  localparam logic [CW-1:0] CNT_MAX  = '1;
  localparam logic [CW-1:0] LAST_IDX = CW'(SLOTS - 1);

  logic          lr_prev, started;
  logic [CW-1:0] cnt, idx_n;
  fmt_e          cur_fmt, use_fmt;
  logic [DW-1:0] sh, sh_base, sh_n, ext;
  logic          hf_edge, take;

  always_comb begin
    hf_edge = bit_lr != lr_prev;
    if (hf_edge)              idx_n = '0;
    else if (cnt == CNT_MAX)  idx_n = cnt;
    else                      idx_n = cnt + 1'b1;
    use_fmt = hf_edge ? fmt_sel : cur_fmt;
    take    = in_window(use_fmt, int'(idx_n), SLOTS, DW);
    sh_base = hf_edge ? '0 : sh;
    if (!take)                   sh_n = sh_base;
    else if (lsb_first(use_fmt)) sh_n = {bit_sd, sh_base[DW-1:1]};
    else                         sh_n = {sh_base[DW-2:0], bit_sd};
  end

  // Sign-extend the finished word from its own top bit.
  always_comb begin
    int len;
    len = word_len(cur_fmt, DW);
    for (int i = 0; i < DW; i++) begin
      ext[i] = (i < len) ? sh[i] : sh[len-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev <= 1'b1;
      started <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      cur_fmt <= FMT_I2S;
      hf_done <= 1'b0;
      hf_ok   <= 1'b0;
      hf_chan <= 1'b0;
      hf_word <= '0;
    end else begin
      hf_done <= 1'b0;
      if (bit_stb) begin
        lr_prev <= bit_lr;
        cnt     <= idx_n;
        sh      <= sh_n;
        if (hf_edge) begin
          started <= 1'b1;
          cur_fmt <= fmt_sel;
          hf_done <= started;
          hf_ok   <= (cnt == LAST_IDX);
          hf_chan <= lr_prev;
          hf_word <= ext;
        end
      end
    end
  end

  // R10: a half-frame closes only on a sampled bit-clock edge.
  p_done_on_edge_r10: assert property (@(posedge clk) disable iff (rst)
    hf_done |-> $past(bit_stb));

endmodule

// File: rtl/ausr_pair.sv
module ausr_pair #(
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hf_done,
  input  logic          hf_ok,
  input  logic          hf_chan,
  input  logic [DW-1:0] hf_word,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] right_o,
  output logic          valid_o,
  output logic          ferr_o
);

  logic [DW-1:0] left_hold;
  logic          have_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      have_left <= 1'b0;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
      ferr_o    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      if (hf_done) begin
        if (!hf_ok) begin
          ferr_o    <= 1'b1;
          have_left <= 1'b0;
        end else if (!hf_chan) begin
          left_hold <= hf_word;
          have_left <= 1'b1;
        end else if (have_left) begin
          left_o    <= left_hold;
          right_o   <= hf_word;
          valid_o   <= 1'b1;
          have_left <= 1'b0;
        end
      end
    end
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    ferr_o |=> !ferr_o);

  p_err_excl_valid_r8: assert property (@(posedge clk) disable iff (rst)
    !(ferr_o && valid_o));

endmodule

// File: rtl/ausr_rx.sv
module ausr_rx
  import ausr_pkg::*;
#(
  parameter int DW          = SAMPLE_W,
  parameter int SLOTS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk,
  input  logic          lrclk,
  input  logic          sdata,
  input  logic [2:0]    fmt_code,
  output logic [DW-1:0] left_sample,
  output logic [DW-1:0] right_sample,
  output logic          sample_valid,
  output logic          frame_err,
  output logic          fmt_err
);

  logic          bit_stb, bit_lr, bit_sd;
  logic          hf_done, hf_ok, hf_chan;
  logic [DW-1:0] hf_word;
  logic [2:0]    fmt_q;
  fmt_e          fmt_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q   <= 3'd0;
      fmt_err <= 1'b0;
    end else begin
      fmt_q   <= fmt_code;
      fmt_err <= (fmt_code == 3'd7);
    end
  end

  assign fmt_sel = fmt_sanitize(fmt_q);

  ausr_bitclk #(.STAGES(SYNC_STAGES)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .bclk_i  (bclk),
    .lr_i    (lrclk),
    .sd_i    (sdata),
    .bit_stb (bit_stb),
    .bit_lr  (bit_lr),
    .bit_sd  (bit_sd)
  );

  ausr_slicer #(.DW(DW), .SLOTS(SLOTS)) u_slicer (
    .clk     (clk),
    .rst     (rst),
    .bit_stb (bit_stb),
    .bit_lr  (bit_lr),
    .bit_sd  (bit_sd),
    .fmt_sel (fmt_sel),
    .hf_done (hf_done),
    .hf_ok   (hf_ok),
    .hf_chan (hf_chan),
    .hf_word (hf_word)
  );

  ausr_pair #(.DW(DW)) u_pair (
    .clk     (clk),
    .rst     (rst),
    .hf_done (hf_done),
    .hf_ok   (hf_ok),
    .hf_chan (hf_chan),
    .hf_word (hf_word),
    .left_o  (left_sample),
    .right_o (right_sample),
    .valid_o (sample_valid),
    .ferr_o  (frame_err)
  );

  // R9: the undefined code decodes as I2S.
  p_undef_as_i2s_r9: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> (fmt_sel == FMT_I2S));

endmodule

// File: tb/ausr_rx_tb.sv
`timescale 1ns/1ps
module ausr_rx_tb;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bclk = 1'b0, lrclk = 1'b1, sdata = 1'b0;
  logic [2:0]  fmt_code = 3'd0;
  logic [23:0] left_sample, right_sample;
  logic        sample_valid, frame_err, fmt_err;

  int n_checks = 0, n_err = 0, n_valid = 0, n_ferr = 0, n_pushed = 0;
  bit fin = 0;
  logic valid_prev = 1'b0;
  logic [23:0] q_l[$], q_r[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  ausr_rx u_dut (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt_code(fmt_code), .left_sample(left_sample), .right_sample(right_sample),
    .sample_valid(sample_valid), .frame_err(frame_err), .fmt_err(fmt_err)
  );

  task automatic check(bit ok, string req, string what, logic [23:0] act, logic [23:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Slot position of a data bit; -1 marks a padding slot.
  function automatic int bit_pos(logic [2:0] f, int i);
    case (f)
      3'd0, 3'd7: return (i >= 1 && i <= 24) ? 24 - i : -1;
      3'd1:       return (i < 24) ? 23 - i : -1;
      3'd2:       return (i >= 8) ? i - 8 : -1;
      3'd3:       return (i >= 8)  ? 31 - i : -1;
      3'd4:       return (i >= 12) ? 31 - i : -1;
      3'd5:       return (i >= 14) ? 31 - i : -1;
      default:    return (i >= 16) ? 31 - i : -1;
    endcase
  endfunction

  function automatic logic [23:0] exp_val(logic [2:0] f, logic [23:0] w);
    case (f)
      3'd4:    return {{4{w[19]}}, w[19:0]};
      3'd5:    return {{6{w[17]}}, w[17:0]};
      3'd6:    return {{8{w[15]}}, w[15:0]};
      default: return w;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (sample_valid) begin
        n_valid++;
        if (valid_prev) check(0, "R7", "valid longer than one cycle", 24'd1, 24'd0);
        if (q_l.size() == 0) begin
          check(0, "R7 R8", "unexpected valid", left_sample, 24'd0);
        end else begin
          automatic logic [23:0] el = q_l.pop_front();
          automatic logic [23:0] er = q_r.pop_front();
          automatic string       tg = q_tag.pop_front();
          check(left_sample == el, tg, "left", left_sample, el);
          check(right_sample == er, tg, "right", right_sample, er);
        end
      end
      if (frame_err) n_ferr++;
    end
    valid_prev <= sample_valid;
  end

  task automatic send_bit(logic lr, logic b);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = b;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_half(logic lr, logic [2:0] f, logic [23:0] w, int nbits);
    for (int i = 0; i < nbits; i++) begin
      automatic int p = bit_pos(f, i);
      send_bit(lr, (i < 32 && p >= 0) ? w[p] : 1'($urandom));
    end
  endtask

  task automatic send_frame(logic [2:0] f, logic [23:0] l, logic [23:0] r, string tag);
    fmt_code = f;
    send_half(1'b0, f, l, 32);
    send_half(1'b1, f, r, 32);
    q_l.push_back(exp_val(f, l));
    q_r.push_back(exp_val(f, r));
    q_tag.push_back(tag);
    n_pushed++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    automatic logic [2:0] prev_f = 3'd0;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check(left_sample == 0 && right_sample == 0, "R1", "samples in reset", left_sample, 24'd0);
    check({sample_valid, frame_err, fmt_err} == 3'b000, "R1", "flags in reset",
          {21'd0, sample_valid, frame_err, fmt_err}, 24'd0);
    rst = 1'b0;
    @(negedge clk);
    check(left_sample == 0 && !sample_valid, "R1", "first cycle after reset", left_sample, 24'd0);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);

    send_frame(3'd0, 24'h800001, 24'h7FFFFE, "R2 i2s");
    send_frame(3'd1, 24'hA5C3F0, 24'h0F1E2D, "R3 left-justified");
    send_frame(3'd2, 24'h812345, 24'h00FF01, "R4 lsb-first");
    send_frame(3'd3, 24'hC00003, 24'h3FFFFC, "R5 rj24");
    send_frame(3'd4, 24'h080000, 24'h07FFFF, "R5 rj20 sign");
    send_frame(3'd5, 24'h020000, 24'h01FFFF, "R5 rj18 sign");
    send_frame(3'd6, 24'h008000, 24'h007FFF, "R5 rj16 sign");
    send_frame(3'd6, 24'hFF1234, 24'h00ABCD, "R6 rj16 upper bits ignored");

    fmt_code = 3'd7;
    repeat (3) @(negedge clk);
    check(fmt_err == 1'b1, "R9", "fmt_err for code 111", {23'd0, fmt_err}, 24'd1);
    send_frame(3'd7, 24'h123456, 24'hFEDCBA, "R9 undefined code as i2s");
    fmt_code = 3'd0;
    repeat (3) @(negedge clk);
    check(fmt_err == 1'b0, "R9", "fmt_err cleared", {23'd0, fmt_err}, 24'd0);

    // Short left half-frame, then a long right half-frame.
    send_half(1'b0, 3'd0, 24'h111111, 31);
    send_half(1'b1, 3'd0, 24'h222222, 32);
    send_half(1'b0, 3'd0, 24'h333333, 32);
    send_half(1'b1, 3'd0, 24'h444444, 33);
    send_frame(3'd1, 24'h5A5A5A, 24'hA5A5A5, "R8 recovery after errors");

    for (int k = 0; k < 40; k++) begin
      automatic logic [2:0] f = 3'($urandom_range(0, 6));
      automatic string tg = (f != prev_f) ? $sformatf("R6 R10 fmt=%0d", f)
                                          : $sformatf("R6 fmt=%0d", f);
      send_frame(f, 24'($urandom), 24'($urandom), tg);
      prev_f = f;
    end

    send_half(1'b0, 3'd0, 24'h000000, 32);
    repeat (20) @(negedge clk);
    check(q_l.size() == 0, "R7", "pairs still pending", 24'(q_l.size()), 24'd0);
    check(n_valid == n_pushed, "R7", "valid count", 24'(n_valid), 24'(n_pushed));
    check(n_ferr == 2, "R8", "frame error count", 24'(n_ferr), 24'd2);

    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule